// File: doc/BRIEF.md
# Shared Comparator Slot Scheduler

This block lets one analog comparator serve both the average-power control loop of a laser driver and its quick-trip alarm checks. It runs a repeating frame of eight comparator slots. Six slots feed the power loop and two check alarm thresholds. For each slot it drives the comparator's input select and reference select. When a sample arrives, it routes the result either to the loop or to the alarm flag that belongs to that slot.

The comparator is outside the block. It is seen as a one-bit result `smp_i` qualified by a strobe `smp_vld_i`. Each strobe closes the current slot and moves the frame on by one. The two alarm slots are slot 3 and slot 7, so the loop samples are spread evenly across the frame. Slot 3 compares the monitor-diode voltage against the power references. It uses the high threshold in even frames and the low threshold in odd frames. Slot 7 compares the bias monitor against the bias-high reference.

There are three alarm flags: power high, power low and bias high. Each flag is a sticky register that is cleared by a one-cycle clear pulse. A flag is masked while the startup search is still running, and it is also masked when its own mask bit is set. A masked flag reads 0 and does not latch.

Top module: `cmp_slot_sched`

## Requirements
- R1: After reset, `slot_o` is 0 and the frame is even. `in_sel_o` is 0, `ref_sel_o` is 0, `loop_vld_o` and `loop_hi_o` are 0, and `alm_o` is 0.
- R2: Each `smp_vld_i` strobe moves `slot_o` on by one, from 7 back to 0. Wrapping from 7 to 0 toggles the frame parity. Without a strobe, `slot_o` holds.
- R3: The selects follow the current slot and change in the cycle after the strobe that enters that slot. The encodings are as follows:
  - Loop slots 0, 1, 2, 4, 5 and 6 use `in_sel_o`=0 (monitor diode) and `ref_sel_o`=0 (loop set point).
  - Slot 3 uses `in_sel_o`=0, with `ref_sel_o`=1 (power high) in an even frame and `ref_sel_o`=2 (power low) in an odd frame.
  - Slot 7 uses `in_sel_o`=1 (bias monitor) and `ref_sel_o`=3 (bias high).
- R4: A strobe in a loop slot gives a one-cycle `loop_vld_o` pulse in the next cycle, with `loop_hi_o` equal to the sample. A strobe in slot 3 or slot 7 gives no loop pulse.
- R5: In slot 3 of an even frame, a sample of 1 sets `alm_o[0]` (power high). In slot 3 of an odd frame, a sample of 0 sets `alm_o[1]` (power low). The opposite sample value sets nothing.
- R6: In slot 7, a sample of 1 sets `alm_o[2]` (bias high). A sample of 0 sets nothing.
- R7: A flag is set only by a strobe in its own slot and is visible in the next cycle. A sample of 1 in a loop slot sets no flag.
- R8: While `search_done_i` is 0, all of `alm_o` read 0 and no flag latches. Raising `search_done_i` later reveals no trip from the masked period.
- R9: While `alm_mask_i[k]` is 1, `alm_o[k]` reads 0 and does not latch. Unmasking later reveals no trip from the masked period.
- R10: An unmasked flag stays set until a one-cycle pulse on `alm_clr_i[k]`. The pulse clears that flag only. If a trip and a clear happen in the same cycle, the trip wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| smp_vld_i | input | 1 | Comparator sample strobe; closes the current slot |
| smp_i | input | 1 | Comparator result, 1 = input above reference |
| search_done_i | input | 1 | Startup search finished; unmasks all alarms |
| alm_mask_i | input | 3 | Per-alarm mask: [0] power high, [1] power low, [2] bias high |
| alm_clr_i | input | 3 | Per-alarm write-one clear pulse |
| slot_o | output | 3 | Current frame slot |
| in_sel_o | output | 1 | Comparator input select: 0 monitor diode, 1 bias monitor |
| ref_sel_o | output | 2 | Reference select: 0 loop, 1 power high, 2 power low, 3 bias high |
| loop_vld_o | output | 1 | Loop sample valid pulse |
| loop_hi_o | output | 1 | Loop sample value |
| alm_o | output | 3 | Masked, latched alarm flags |

## Verification
The assertions assume that `smp_vld_i` is never high in two consecutive cycles. This leaves the selects at least one full cycle to settle before the comparator is sampled again. The stable-select check and the strobe-gap check both rely on that assumption. The stimulus always leaves at least one idle cycle after each strobe, and the gap varies from one to three cycles. Clear pulses are issued only between strobes, so they never meet a trip in the same cycle.

// File: rtl/cmp_slot_pkg.sv
package cmp_slot_pkg;

  typedef enum logic [1:0] {
    REF_LOOP    = 2'd0,
    REF_PWR_HI  = 2'd1,
    REF_PWR_LO  = 2'd2,
    REF_BIAS_HI = 2'd3
  } ref_sel_e;

  typedef enum logic {
    IN_MON_DIODE = 1'b0,
    IN_BIAS_MON  = 1'b1
  } in_sel_e;

  typedef enum logic [1:0] {
    KIND_LOOP = 2'd0,
    KIND_PWR  = 2'd1,
    KIND_BIAS = 2'd2
  } slot_kind_e;

  localparam int unsigned ALM_PWR_HI  = 0;
  localparam int unsigned ALM_PWR_LO  = 1;
  localparam int unsigned ALM_BIAS_HI = 2;
  localparam int unsigned NUM_ALM     = 3;

endpackage

// File: rtl/slot_seq.sv
module slot_seq
  import cmp_slot_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned PWR_SLOT  = 3,
  parameter int unsigned BIAS_SLOT = 7,
  localparam int unsigned SW = $clog2(NUM_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          adv_i,
  output logic [SW-1:0] slot_o,
  output logic          odd_frame_o,
  output slot_kind_e    kind_o,
  output logic          in_sel_o,
  output logic [1:0]    ref_sel_o
);

  logic [SW-1:0] slot_q;
  logic          odd_q;
  logic          last_slot;

  assign last_slot = (slot_q == SW'(NUM_SLOTS - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      slot_q <= '0;
      odd_q  <= 1'b0;
    end else if (adv_i) begin
      slot_q <= last_slot ? '0 : slot_q + SW'(1);
      if (last_slot) odd_q <= ~odd_q;
    end
  end

  always_comb begin
    kind_o    = KIND_LOOP;
    in_sel_o  = IN_MON_DIODE;
    ref_sel_o = REF_LOOP;
    if (slot_q == SW'(PWR_SLOT)) begin
      kind_o    = KIND_PWR;
      ref_sel_o = odd_q ? REF_PWR_LO : REF_PWR_HI;
    end else if (slot_q == SW'(BIAS_SLOT)) begin
      kind_o    = KIND_BIAS;
      in_sel_o  = IN_BIAS_MON;
      ref_sel_o = REF_BIAS_HI;
    end
  end

  assign slot_o      = slot_q;
  assign odd_frame_o = odd_q;

  // R2: one step per strobe, wrap at the frame end
  a_r2_slot_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> slot_q == (($past(slot_q) == SW'(NUM_SLOTS - 1)) ? '0 : $past(slot_q) + SW'(1)));

  a_r2_slot_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(slot_q) && $stable(odd_q));

  a_r2_parity_on_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i && slot_q == SW'(NUM_SLOTS - 1) |=> odd_q != $past(odd_q));

  // R3: input contract, selects must have settled for a full cycle at each strobe
  a_r3_strobe_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |=> !adv_i);

  a_r3_sel_settled: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> $stable(ref_sel_o) && $stable(in_sel_o));

endmodule

// File: rtl/loop_port.sv
module loop_port (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic take_i,
  input  logic smp_i,
  output logic vld_o,
  output logic hi_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o <= 1'b0;
      hi_o  <= 1'b0;
    end else begin
      vld_o <= take_i;
      if (take_i) hi_o <= smp_i;
    end
  end

  // R4: loop pulse is a single cycle since strobes never come back to back
  a_r4_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_o |=> !vld_o);

endmodule

// File: rtl/alarm_bank.sv
module alarm_bank #(
  parameter int unsigned N = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] trip_i,
  input  logic [N-1:0] en_i,
  input  logic [N-1:0] clr_i,
  output logic [N-1:0] alm_o
);

  logic [N-1:0] lat_q;

  for (genvar k = 0; k < N; k++) begin : g_flag
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                  lat_q[k] <= 1'b0;
      else if (trip_i[k] && en_i[k]) lat_q[k] <= 1'b1;  // trip beats clear
      else if (clr_i[k])            lat_q[k] <= 1'b0;
    end

    assign alm_o[k] = lat_q[k] & en_i[k];

    // R7: a flag rises only from an enabled trip of its own
    a_r7_rise_from_trip: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(lat_q[k]) |-> $past(trip_i[k] && en_i[k]));

    // R10: sticky until cleared
    a_r10_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      lat_q[k] && !clr_i[k] |=> lat_q[k]);

    // R8, R9: a masked flag cannot latch
    a_r9_masked_no_latch: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !en_i[k] && !lat_q[k] |=> !lat_q[k]);
  end

endmodule

// File: rtl/cmp_slot_sched.sv
module cmp_slot_sched
  import cmp_slot_pkg::*;
#(
  parameter int unsigned NUM_SLOTS = 8,
  parameter int unsigned PWR_SLOT  = 3,
  parameter int unsigned BIAS_SLOT = 7,
  localparam int unsigned SW = $clog2(NUM_SLOTS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          smp_vld_i,
  input  logic          smp_i,
  input  logic          search_done_i,
  input  logic [2:0]    alm_mask_i,
  input  logic [2:0]    alm_clr_i,
  output logic [SW-1:0] slot_o,
  output logic          in_sel_o,
  output logic [1:0]    ref_sel_o,
  output logic          loop_vld_o,
  output logic          loop_hi_o,
  output logic [2:0]    alm_o
);

  slot_kind_e           kind;
  logic                 odd_frame;
  logic [NUM_ALM-1:0]   trip;
  logic [NUM_ALM-1:0]   alm_en;

  slot_seq #(
    .NUM_SLOTS (NUM_SLOTS),
    .PWR_SLOT  (PWR_SLOT),
    .BIAS_SLOT (BIAS_SLOT)
  ) i_seq (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .adv_i       (smp_vld_i),
    .slot_o      (slot_o),
    .odd_frame_o (odd_frame),
    .kind_o      (kind),
    .in_sel_o    (in_sel_o),
    .ref_sel_o   (ref_sel_o)
  );

  loop_port i_loop (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .take_i (smp_vld_i && kind == KIND_LOOP),
    .smp_i  (smp_i),
    .vld_o  (loop_vld_o),
    .hi_o   (loop_hi_o)
  );

  // high thresholds trip on "above", the low threshold trips on "below"
  always_comb begin
    trip              = '0;
    trip[ALM_PWR_HI]  = smp_vld_i && kind == KIND_PWR  && !odd_frame &&  smp_i;
    trip[ALM_PWR_LO]  = smp_vld_i && kind == KIND_PWR  &&  odd_frame && !smp_i;
    trip[ALM_BIAS_HI] = smp_vld_i && kind == KIND_BIAS &&  smp_i;
  end

  assign alm_en = {NUM_ALM{search_done_i}} & ~alm_mask_i;

  alarm_bank #(.N(NUM_ALM)) i_alm (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .trip_i (trip),
    .en_i   (alm_en),
    .clr_i  (alm_clr_i),
    .alm_o  (alm_o)
  );

  // R4: alarm slots never reach the loop
  a_r4_no_loop_in_alarm_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && kind != KIND_LOOP |=> !loop_vld_o);

  a_r4_loop_value: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && kind == KIND_LOOP |=> loop_vld_o && loop_hi_o == $past(smp_i));

  // R7: a strobe in a loop slot leaves the flags alone
  a_r7_loop_slot_no_alarm: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smp_vld_i && kind == KIND_LOOP && alm_clr_i == '0 && alm_en == $past(alm_en)
      |=> alm_o == $past(alm_o) || $changed(alm_en));

endmodule

// File: tb/test_cmp_slot_sched.sv
module test_cmp_slot_sched;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       smp_vld = 1'b0;
  logic       smp = 1'b0;
  logic       done = 1'b0;
  logic [2:0] mask = '0;
  logic [2:0] clr = '0;
  logic [2:0] slot;
  logic       in_sel;
  logic [1:0] ref_sel;
  logic       loop_vld;
  logic       loop_hi;
  logic [2:0] alm;

  int n_chk = 0;
  int n_bad = 0;

  // model state
  int         m_slot = 0;
  bit         m_odd = 1'b0;
  logic [2:0] m_lat = '0;

  logic [10:0] exp_q[$];
  string       tag_q[$];

  always #5 clk = ~clk;

  cmp_slot_sched i_cmp_slot_sched (
    .clk_i         (clk),
    .rst_ni        (rst_n),
    .smp_vld_i     (smp_vld),
    .smp_i         (smp),
    .search_done_i (done),
    .alm_mask_i    (mask),
    .alm_clr_i     (clr),
    .slot_o        (slot),
    .in_sel_o      (in_sel),
    .ref_sel_o     (ref_sel),
    .loop_vld_o    (loop_vld),
    .loop_hi_o     (loop_hi),
    .alm_o         (alm)
  );

  function automatic logic [2:0] en_vec();
    return done ? ~mask : 3'b000;
  endfunction

  // {slot, in_sel, ref_sel, loop_vld, loop_hi, alm}
  function automatic logic [10:0] pack(int s, bit odd, bit lv, bit lh, logic [2:0] a);
    logic       is;
    logic [1:0] rs;
    is = 1'b0;
    rs = 2'd0;
    if (s == 3) rs = odd ? 2'd2 : 2'd1;
    if (s == 7) begin is = 1'b1; rs = 2'd3; end
    return {3'(s), is, rs, lv, lh, a};
  endfunction

  function automatic logic [10:0] act_vec();
    return {slot, in_sel, ref_sel, loop_vld, loop_hi, alm};
  endfunction

  task automatic check(string tag, logic [10:0] act, logic [10:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  // driver: one strobe, then gap idle cycles
  task automatic strobe(bit s, int gap, string tag);
    logic [2:0] en;
    bit lv;
    @(negedge clk);
    en = en_vec();
    lv = (m_slot != 3 && m_slot != 7);
    if (m_slot == 3 && !m_odd && s && en[0]) m_lat[0] = 1'b1;
    if (m_slot == 3 && m_odd && !s && en[1]) m_lat[1] = 1'b1;
    if (m_slot == 7 && s && en[2]) m_lat[2] = 1'b1;
    if (m_slot == 7) begin m_slot = 0; m_odd = ~m_odd; end
    else m_slot++;
    exp_q.push_back(pack(m_slot, m_odd, lv, lv ? s : loop_hi, m_lat & en));
    tag_q.push_back(tag);
    smp_vld = 1'b1;
    smp = s;
    @(negedge clk);
    smp_vld = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  task automatic frame(logic [7:0] s, string tag);
    for (int i = 0; i < 8; i++) strobe(s[i], 1 + (i % 3), tag);
  endtask

  task automatic clear(logic [2:0] b, string tag);
    @(negedge clk);
    clr = b;
    @(negedge clk);
    clr = '0;
    m_lat = m_lat & ~b;
    @(negedge clk);
    check(tag, {5'b0, alm}, {5'b0, m_lat & en_vec()});
  endtask

  // monitor: compares after each strobe edge settles
  initial begin
    forever begin
      @(posedge clk);
      if (smp_vld && rst_n) begin
        #2;
        check(tag_q.pop_front(), act_vec(), exp_q.pop_front());
      end
    end
  end

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog act=running exp=finished");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset", act_vec(), pack(0, 1'b0, 1'b0, 1'b0, 3'b000));

    // R8 search not done: trips on every alarm slot must be swallowed
    frame(8'hFF, "R8 masked even frame");
    frame(8'h00, "R8 masked odd frame");
    done = 1'b1;
    @(negedge clk);
    check("R8 no leak after unmask", {8'b0, alm}, 11'b0);

    // R2 R3 R4 R7: loop traffic, alarm slots quiet
    frame(8'b0011_0101, "R4 R5 R7 even no-trip");
    frame(8'b0111_1111, "R7 R5 odd no-trip");
    // R2 hold: slot stays without strobes
    repeat (5) @(negedge clk);
    check("R2 hold", act_vec(), pack(m_slot, m_odd, 1'b0, loop_hi, m_lat));

    // R5 power high in even frame, R6 bias high
    frame(8'b1000_1000, "R5 R6 even trips");
    // R5 power low in odd frame
    frame(8'b1111_0111, "R5 odd low trip");
    repeat (4) @(negedge clk);
    check("R10 sticky", {8'b0, alm}, {8'b0, 3'b111});

    // R10 clear one flag only
    clear(3'b001, "R10 clear hi only");
    clear(3'b110, "R10 clear rest");

    // R9 per-flag mask
    mask = 3'b010;
    frame(8'hFF, "R9 even with low masked");
    frame(8'h00, "R9 odd low masked");
    mask = 3'b000;
    @(negedge clk);
    check("R9 no leak after unmask", {8'b0, alm}, {8'b0, m_lat});
    clear(3'b111, "R10 final clear");

    // R6 slot 7 zero sets nothing, R3 across another frame
    frame(8'b0101_0101, "R3 R6 sel sweep");

    repeat (3) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule